// File: doc/BRIEF.md
# Address-masked GPIO data port

An eight-line general-purpose I/O port on a simple APB-style register bus. A direction register chooses, pin by pin, whether the port drives the pin or listens to it. Every pin has an output value with a matching output enable, and an input level that passes through a two-flop synchronizer before the bus can see it.

Data accesses use a window below the direction register. Inside that window, address bits [9:2] act as a pin mask: bit n+2 of the address selects pin n. A write changes only the selected output bits, so software can set or clear one pin in a single store with no read-modify-write. A read returns the selected pins and zero elsewhere. Every access completes in one transfer with no wait states.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset every pin is an input (`gpio_oe` = 0x00) and the output value register is 0x00 (`gpio_out` = 0x00).
- R2: A write to offset 0x400 loads the direction register; bit n = 1 makes pin n an output, and `gpio_oe` shows the new value from the clock edge that ends the access phase. A read of 0x400 returns the direction register.
- R3: A write to an offset below 0x400 updates output bit n only when address bit n+2 is 1; every other output bit keeps its value.
- R4: A data write to a pin that is an input at the time of the write is dropped; that output bit keeps its earlier value, which is what the pin drives if it is later turned into an output.
- R5: A read from an offset below 0x400 returns 0 in every bit position whose address mask bit (address bit n+2) is 0.
- R6: In a selected position, a data read returns the driven value for an output pin and the synchronized external level for an input pin; a change on `gpio_in` is visible after two rising clock edges and not after one.
- R7: `pready` is always 1; writes take effect at the access-phase clock edge and reads are valid combinationally while `psel` is high.
- R8: Reads of offsets at or above 0x400 other than 0x400 return 0, and writes to them change neither `gpio_out` nor `gpio_oe`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus and port clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address |
| pwdata | input | 8 | Write data |
| prdata | output | 8 | Read data |
| pready | output | 1 | Transfer complete, tied high |
| gpio_in | input | 8 | External pin levels |
| gpio_out | output | 8 | Output values |
| gpio_oe | output | 8 | Output enables, 1 = drive |

## Verification
The hardest case to reach is the interplay of direction and mask: a data write that selects a mix of input and output pins, followed by a direction change that exposes the dropped bits. The vector table walks a running state where each step changes direction, writes through a partial mask and reads through a different mask, so dropped writes to input pins later show up as stale values on `gpio_out`. Synchronizer latency is checked by holding a setup-phase read open across clock edges and watching the value change only after the second edge.

// File: rtl/gpio_mask_port.sv
module gpio_mask_port #(
  parameter int NPIN     = 8,
  parameter int AW       = 12,
  parameter int DIR_ADDR = 'h400
) (
  input  logic            pclk,
  input  logic            presetn,
  input  logic            psel,
  input  logic            penable,
  input  logic            pwrite,
  input  logic [AW-1:0]   paddr,
  input  logic [NPIN-1:0] pwdata,
  output logic [NPIN-1:0] prdata,
  output logic            pready,
  input  logic [NPIN-1:0] gpio_in,
  output logic [NPIN-1:0] gpio_out,
  output logic [NPIN-1:0] gpio_oe
);
  localparam logic [AW-1:0] DIR_A = AW'(DIR_ADDR);

  logic [NPIN-1:0] dir_q, out_q, sync1_q, sync2_q;
  logic [NPIN-1:0] amask, pin_val;
  logic            hit_data, hit_dir, wr_en;

  assign amask    = paddr[NPIN+1:2];
  assign hit_data = paddr < DIR_A;
  assign hit_dir  = paddr == DIR_A;
  assign wr_en    = psel && penable && pwrite;
  assign pin_val  = (out_q & dir_q) | (sync2_q & ~dir_q);

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      dir_q <= '0;
      out_q <= '0;
    end else if (wr_en) begin
      if (hit_dir)
        dir_q <= pwdata;
      else if (hit_data)
        out_q <= (out_q & ~(amask & dir_q)) | (pwdata & amask & dir_q);
    end
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= gpio_in;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      if (hit_dir)       prdata = dir_q;
      else if (hit_data) prdata = pin_val & amask;
    end
  end

  assign pready   = 1'b1;
  assign gpio_out = out_q;
  assign gpio_oe  = dir_q;
endmodule

module gpio_mask_port_chk #(
  parameter int NPIN     = 8,
  parameter int AW       = 12,
  parameter int DIR_ADDR = 'h400
) (
  input logic            pclk,
  input logic            presetn,
  input logic            psel,
  input logic            penable,
  input logic            pwrite,
  input logic [AW-1:0]   paddr,
  input logic [NPIN-1:0] pwdata,
  input logic [NPIN-1:0] prdata,
  input logic            pready,
  input logic [NPIN-1:0] gpio_out,
  input logic [NPIN-1:0] gpio_oe
);
  localparam logic [AW-1:0] DIR_A = AW'(DIR_ADDR);

  assert_reset_idle_R1: assert property (@(posedge pclk) disable iff (!presetn)
    $rose(presetn) |-> (gpio_oe == '0 && gpio_out == '0));

  assert_dir_load_R2: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && pwrite && paddr == DIR_A) |=> gpio_oe == $past(pwdata));

  assert_mask_keep_R3: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && pwrite && paddr < DIR_A)
      |=> ((gpio_out ^ $past(gpio_out)) & ~$past(paddr[NPIN+1:2])) == '0);

  assert_input_drop_R4: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && pwrite && paddr < DIR_A)
      |=> ((gpio_out ^ $past(gpio_out)) & ~$past(gpio_oe)) == '0);

  assert_read_masked_R5: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && !pwrite && paddr < DIR_A) |-> (prdata & ~paddr[NPIN+1:2]) == '0);

  assert_no_wait_R7: assert property (@(posedge pclk) disable iff (!presetn)
    pready);

  assert_unmapped_read_R8: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && !pwrite && paddr > DIR_A) |-> prdata == '0);

  assert_unmapped_write_R8: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && pwrite && paddr > DIR_A) |=> ($stable(gpio_out) && $stable(gpio_oe)));
endmodule

bind gpio_mask_port gpio_mask_port_chk #(.NPIN(NPIN), .AW(AW), .DIR_ADDR(DIR_ADDR)) chk_i (.*);

// File: tb/gpio_mask_port_tb.sv
module gpio_mask_port_tb_top;
  logic        pclk = 0, presetn = 0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [7:0]  pwdata = '0, gpio_in = '0;
  logic [7:0]  prdata, gpio_out, gpio_oe;
  logic        pready;
  int checks = 0, fails = 0;

  always #2 pclk = ~pclk;

  gpio_mask_port dut_i (.*);

  // dir, wmask, wdata, pins, rmask, exp_out, exp_rd
  localparam logic [55:0] VEC [6] = '{
    {8'hFF, 8'hFF, 8'hA5, 8'h00, 8'hFF, 8'hA5, 8'hA5},
    {8'hFF, 8'h0F, 8'h3C, 8'hFF, 8'hF0, 8'hAC, 8'hA0},
    {8'h0F, 8'hFF, 8'h53, 8'hC6, 8'hFF, 8'hA3, 8'hC3},
    {8'h00, 8'hFF, 8'hFF, 8'h5A, 8'h3C, 8'hA3, 8'h18},
    {8'hF0, 8'h81, 8'h00, 8'h0F, 8'hFF, 8'h23, 8'h2F},
    {8'h01, 8'h01, 8'h00, 8'hFF, 8'h03, 8'h22, 8'h02}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge pclk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [7:0] d);
    @(negedge pclk); psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge pclk); penable = 1; #1 d = prdata;
    @(negedge pclk); psel = 0; penable = 0;
  endtask

  function automatic logic [11:0] win(input logic [7:0] m);
    return {2'b00, m, 2'b00};
  endfunction

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge pclk);
    chk("R1 oe", gpio_oe, 8'h00);
    chk("R1 out", gpio_out, 8'h00);
    presetn = 1;
    bus_rd(12'h400, rd); chk("R1 dir read", rd, 8'h00);
    chk("R7 pready", {7'b0, pready}, 8'h01);

    for (int i = 0; i < 6; i++) begin
      logic [7:0] v_dir, v_wm, v_wd, v_pin, v_rm, v_out, v_rd;
      {v_dir, v_wm, v_wd, v_pin, v_rm, v_out, v_rd} = VEC[i];
      bus_wr(12'h400, v_dir);
      chk("R2 oe after write", gpio_oe, v_dir);
      bus_wr(win(v_wm), v_wd);
      chk("R3 R4 R7 out after masked write", gpio_out, v_out);
      gpio_in = v_pin;
      repeat (3) @(negedge pclk);
      bus_rd(win(v_rm), rd);
      chk("R5 R6 masked read", rd, v_rd);
    end

    bus_rd(12'h400, rd); chk("R2 dir readback", rd, 8'h01);

    // R4: dropped input-pin write shows once the pin becomes output
    bus_wr(12'h400, 8'h00);
    bus_wr(win(8'h80), 8'h80);
    chk("R4 write to input dropped", gpio_out, 8'h22);
    bus_wr(12'h400, 8'h80);
    chk("R4 stale value after switch", gpio_out, 8'h22);
    bus_wr(win(8'h80), 8'h80);
    chk("R4 rewrite after switch", gpio_out, 8'hA2);

    // R8: unmapped offsets
    bus_wr(12'h404, 8'hFF);
    chk("R8 unmapped write out", gpio_out, 8'hA2);
    chk("R8 unmapped write oe", gpio_oe, 8'h80);
    bus_rd(12'h404, rd); chk("R8 unmapped read", rd, 8'h00);
    bus_rd(12'hFFC, rd); chk("R8 top read", rd, 8'h00);

    // R6: two-flop latency, setup-phase read held open
    bus_wr(12'h400, 8'h00);
    gpio_in = 8'h00;
    repeat (3) @(negedge pclk);
    psel = 1; pwrite = 0; penable = 0; paddr = win(8'hFF); gpio_in = 8'h55;
    #1 chk("R6 before edges", prdata, 8'h00);
    @(negedge pclk); #1 chk("R6 after one edge", prdata, 8'h00);
    @(negedge pclk); #1 chk("R6 after two edges", prdata, 8'h55);
    psel = 0;

    // R5: single-bit selection on a data read
    bus_rd(win(8'h04), rd); chk("R5 single bit", rd, 8'h04);
    bus_rd(win(8'h00), rd); chk("R5 empty mask", rd, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule